// File: doc/BRIEF.md
# SPI FIFO Interrupt and Level Unit

This block holds the interrupt and FIFO occupancy logic of a memory-mapped SPI master. It keeps a byte count for a 64-entry transmit FIFO and a 64-entry receive FIFO. It also keeps a burst counter that is loaded with the transfer length. From these it derives three interrupt sources. The first is a transmit-low level, set when a quarter of the FIFO or less is filled. The second is a receive-high level, set when three quarters or more of the FIFO is filled. The third is a sticky transfer-done event. The serial shifter and the data storage sit outside. They appear here only as push and pop strobes, one per byte, and a load strobe for the burst length.

Software reaches the block over a small register bus with strobes for reads and writes. It can set which sources are enabled, acknowledge pending sources by writing ones, and read both fill levels. The single interrupt output is registered. The two level sources re-assert after an acknowledge as long as their condition still holds. For that reason, the only way to stop a persistent low-FIFO interrupt is to clear its enable bit. This matters most during receive-only bursts, when the transmit FIFO stays empty.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset, the enable register reads 0, both fill counts read 0 and `irq_o` is low.
- R2: The enable register is at offset 0x0C. Only bit 4 (receive-high), bit 12 (transmit-low) and bit 16 (done) are stored. All other bits read as 0.
- R3: The status register is at offset 0x10 and uses the same bit positions as the enable register. Writing a 1 to a bit clears it. Writing a 0 leaves the bit unchanged.
- R4: Status bit 12 is set on the cycle after the transmit count is 16 or less, including right after reset when the FIFO is empty. If it is cleared while the count is still 16 or less, it reads 0 for one cycle and is then set again.
- R5: Status bit 4 is set on the cycle after the receive count reaches 48 or more. A count of 47 leaves it clear.
- R6: Status bit 16 is set once, on the byte strobe that takes the burst counter from 1 to 0. It stays set until a 1 is written to it, and it does not come back while the burst counter stays at 0.
- R7: `irq_o` is a register that equals the OR over all sources of (status AND enable), taken from the previous cycle.
- R8: A status bit that is pending while its enable bit is clear does not raise `irq_o`. Clearing the enable bit drops `irq_o` one cycle later.
- R9: The level register is at offset 0x1C. The receive count is in bits 6:0 and the transmit count is in bits 22:16. Each count runs from 0 to 64.
- R10: A transmit push when the count is 64 is ignored, and a receive pop when the count is 0 is ignored. Neither changes the counts.
- R11: Read data appears on `rdata_o` in the cycle after `rd_en_i`. An unmapped offset reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| tx_push_i | input | 1 | One byte written into the transmit FIFO |
| tx_pop_i | input | 1 | Shifter takes one byte from the transmit FIFO |
| rx_push_i | input | 1 | Shifter delivers one byte to the receive FIFO; also counts one burst byte |
| rx_pop_i | input | 1 | One byte read from the receive FIFO |
| burst_load_i | input | 1 | Load the burst counter |
| burst_len_i | input | 16 | Burst length in bytes |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that every strobe is a clean single-cycle level, synchronous to the clock. They also assume that a write to the status register and a pop or push on the same edge mean what the requirements say, with an acknowledge taking effect before the level condition is looked at again. The stimulus changes inputs only on falling edges and never asserts a read and a write together. It loads the burst counter only while no receive push is active, and it drives each strobe for exactly one cycle. The bench steps the counts across the exact thresholds (17 to 16, 47 to 48) and past both ends of the FIFO, so the boundary behaviour is observed at the register ports.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    // Register offsets on the control bus
    localparam int unsigned OFS_IEN = 32'h0C;
    localparam int unsigned OFS_STA = 32'h10;
    localparam int unsigned OFS_LVL = 32'h1C;

    // Source bit positions, shared by the enable and status words
    localparam int unsigned BIT_RXHI = 4;
    localparam int unsigned BIT_TXLO = 12;
    localparam int unsigned BIT_DONE = 16;

    // Bit position of the transmit count inside the level word
    localparam int unsigned LVL_TX_LSB = 16;

    typedef struct packed {
        logic done;
        logic tx_low;
        logic rx_high;
    } irq_vec_t;

endpackage

// File: rtl/spi_fifo_level.sv
module spi_fifo_level #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          push_i,
    input  logic          pop_i,
    output logic [CW-1:0] level_o
);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          do_push, do_pop;

    always_comb begin
        do_push = push_i && (cnt_q != CW'(DEPTH));
        do_pop  = pop_i  && (cnt_q != '0);
        cnt_d   = cnt_q;
        if (do_push && !do_pop) begin
            cnt_d = cnt_q + CW'(1);
        end else if (do_pop && !do_push) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign level_o = cnt_q;

endmodule

// File: rtl/spi_burst_ctr.sv
module spi_burst_ctr #(
    parameter int unsigned BW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [BW-1:0] len_i,
    input  logic          byte_i,
    output logic          done_o
);

    logic [BW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = len_i;
        end else if (byte_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - BW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Completion event: the last byte of the burst is exchanged
    assign done_o = byte_i && !load_i && (cnt_q == BW'(1));

endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
    import spi_irq_pkg::*;
#(
    parameter int unsigned AW      = 8,
    parameter int unsigned DW      = 32,
    parameter int unsigned CW      = 7,
    parameter int unsigned TX_LOW  = 16,
    parameter int unsigned RX_HIGH = 48
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [CW-1:0] tx_lvl_i,
    input  logic [CW-1:0] rx_lvl_i,
    input  logic          done_evt_i,
    output logic [DW-1:0] rdata_o,
    output irq_vec_t      sta_o,
    output irq_vec_t      ien_o,
    output logic          irq_o
);

    typedef struct packed {
        irq_vec_t      ien;
        irq_vec_t      sta;
        logic          irq;
        logic [DW-1:0] rdata;
    } state_t;

    state_t   s_d, s_q;
    irq_vec_t clr, wsel;
    logic     tx_cond, rx_cond;

    function automatic logic [DW-1:0] pack_word(input irq_vec_t v);
        logic [DW-1:0] w;
        w           = '0;
        w[BIT_RXHI] = v.rx_high;
        w[BIT_TXLO] = v.tx_low;
        w[BIT_DONE] = v.done;
        return w;
    endfunction

    always_comb begin
        s_d          = s_q;
        tx_cond      = (tx_lvl_i <= CW'(TX_LOW));
        rx_cond      = (rx_lvl_i >= CW'(RX_HIGH));

        wsel.rx_high = wdata_i[BIT_RXHI];
        wsel.tx_low  = wdata_i[BIT_TXLO];
        wsel.done    = wdata_i[BIT_DONE];

        clr = '0;
        if (wr_en_i && (addr_i == AW'(OFS_STA))) begin
            clr = wsel;
        end
        if (wr_en_i && (addr_i == AW'(OFS_IEN))) begin
            s_d.ien = wsel;
        end

        // Level sources: acknowledge wins for one cycle, then the level re-sets
        s_d.sta.tx_low  = clr.tx_low  ? 1'b0 : (s_q.sta.tx_low  | tx_cond);
        s_d.sta.rx_high = clr.rx_high ? 1'b0 : (s_q.sta.rx_high | rx_cond);
        // Event source: a new event is never lost to a concurrent acknowledge
        s_d.sta.done    = done_evt_i | (s_q.sta.done & ~clr.done);

        s_d.irq = |(s_q.sta & s_q.ien);

        if (rd_en_i) begin
            s_d.rdata = '0;
            if (addr_i == AW'(OFS_IEN)) begin
                s_d.rdata = pack_word(s_q.ien);
            end else if (addr_i == AW'(OFS_STA)) begin
                s_d.rdata = pack_word(s_q.sta);
            end else if (addr_i == AW'(OFS_LVL)) begin
                s_d.rdata[CW-1:0]             = rx_lvl_i;
                s_d.rdata[LVL_TX_LSB +: CW]   = tx_lvl_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata_o = s_q.rdata;
    assign sta_o   = s_q.sta;
    assign ien_o   = s_q.ien;
    assign irq_o   = s_q.irq;

endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
    import spi_irq_pkg::*;
#(
    parameter int unsigned DEPTH   = 64,
    parameter int unsigned BURST_W = 16,
    parameter int unsigned AW      = 8,
    parameter int unsigned DW      = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [AW-1:0]      addr_i,
    input  logic [DW-1:0]      wdata_i,
    output logic [DW-1:0]      rdata_o,
    input  logic               tx_push_i,
    input  logic               tx_pop_i,
    input  logic               rx_push_i,
    input  logic               rx_pop_i,
    input  logic               burst_load_i,
    input  logic [BURST_W-1:0] burst_len_i,
    output logic               irq_o
);

    localparam int unsigned CW      = $clog2(DEPTH + 1);
    localparam int unsigned TX_LOW  = DEPTH / 4;
    localparam int unsigned RX_HIGH = (DEPTH * 3) / 4;
    localparam int unsigned NFIFO   = 2;

    logic [NFIFO-1:0]  push_w, pop_w;
    logic [CW-1:0]     lvl_w [NFIFO];
    logic [CW-1:0]     tx_lvl_w, rx_lvl_w;
    logic              done_evt_w;
    irq_vec_t          sta_w, ien_w;

    // Index 0: transmit FIFO, index 1: receive FIFO
    assign push_w = {rx_push_i, tx_push_i};
    assign pop_w  = {rx_pop_i,  tx_pop_i};

    for (genvar g = 0; g < NFIFO; g++) begin : gen_lvl
        spi_fifo_level #(.DEPTH(DEPTH)) u_lvl (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .push_i  (push_w[g]),
            .pop_i   (pop_w[g]),
            .level_o (lvl_w[g])
        );
    end

    assign tx_lvl_w = lvl_w[0];
    assign rx_lvl_w = lvl_w[1];

    spi_burst_ctr #(.BW(BURST_W)) u_burst (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (burst_load_i),
        .len_i  (burst_len_i),
        .byte_i (rx_push_i),
        .done_o (done_evt_w)
    );

    spi_irq_regs #(
        .AW      (AW),
        .DW      (DW),
        .CW      (CW),
        .TX_LOW  (TX_LOW),
        .RX_HIGH (RX_HIGH)
    ) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .tx_lvl_i   (tx_lvl_w),
        .rx_lvl_i   (rx_lvl_w),
        .done_evt_i (done_evt_w),
        .rdata_o    (rdata_o),
        .sta_o      (sta_w),
        .ien_o      (ien_w),
        .irq_o      (irq_o)
    );

endmodule

module spi_fifo_irq_unit_chk
    import spi_irq_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned AW    = 8,
    parameter int unsigned DW    = 32,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          wr_en_i,
    input logic [AW-1:0] addr_i,
    input logic [DW-1:0] wdata_i,
    input logic          tx_push_i,
    input logic          tx_pop_i,
    input logic          rx_push_i,
    input logic          rx_pop_i,
    input logic [CW-1:0] tx_lvl,
    input logic [CW-1:0] rx_lvl,
    input irq_vec_t      sta,
    input irq_vec_t      ien,
    input logic          irq_o
);

    localparam int unsigned TX_LOW = DEPTH / 4;

    logic sta_wr, clr_tx, clr_done;
    assign sta_wr   = wr_en_i && (addr_i == AW'(OFS_STA));
    assign clr_tx   = sta_wr && wdata_i[BIT_TXLO];
    assign clr_done = sta_wr && wdata_i[BIT_DONE];

    // R9
    lvl_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_lvl <= CW'(DEPTH)) && (rx_lvl <= CW'(DEPTH)));

    // R10
    tx_full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_push_i && !tx_pop_i && tx_lvl == CW'(DEPTH)) |=> (tx_lvl == CW'(DEPTH)));

    // R10
    rx_empty_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_pop_i && !rx_push_i && rx_lvl == '0) |=> (rx_lvl == '0));

    // R4
    tx_low_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_lvl <= CW'(TX_LOW) && !clr_tx) |=> sta.tx_low);

    // R6
    done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sta.done && !clr_done) |=> sta.done);

    // R7
    irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(|(sta & ien)));

    // R8
    irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ien == '0) |=> !irq_o);

endmodule

bind spi_fifo_irq_unit spi_fifo_irq_unit_chk #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .DW    (DW)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .tx_push_i (tx_push_i),
    .tx_pop_i  (tx_pop_i),
    .rx_push_i (rx_push_i),
    .rx_pop_i  (rx_pop_i),
    .tx_lvl    (tx_lvl_w),
    .rx_lvl    (rx_lvl_w),
    .sta       (sta_w),
    .ien       (ien_w),
    .irq_o     (irq_o)
);

// File: tb/spi_fifo_irq_unit_test.sv
`timescale 1ns/1ps
module spi_fifo_irq_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic        bload = 1'b0;
    logic [15:0] blen = '0;
    logic        irq;

    int          total = 0;
    int          bad = 0;
    bit          finished = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;
    logic [31:0] e_word;
    string       e_tag;

    always #4 clk = ~clk;

    spi_fifo_irq_unit uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .wr_en_i      (wr_en),
        .rd_en_i      (rd_en),
        .addr_i       (addr),
        .wdata_i      (wdata),
        .rdata_o      (rdata),
        .tx_push_i    (tx_push),
        .tx_pop_i     (tx_pop),
        .rx_push_i    (rx_push),
        .rx_pop_i     (rx_pop),
        .burst_load_i (bload),
        .burst_len_i  (blen),
        .irq_o        (irq)
    );

    // Monitor: a read accepted on a rising edge is compared at the next falling edge
    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL scoreboard: read with no expected entry, got %h", rdata);
            end else begin
                e_word = exp_q.pop_front();
                e_tag  = tag_q.pop_front();
                if (rdata !== e_word) begin
                    bad++;
                    $display("FAIL %s: got %h expected %h", e_tag, rdata, e_word);
                end
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        rd_en = 1'b1;
        addr  = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    // which: 0 tx push, 1 tx pop, 2 rx push, 3 rx pop
    task automatic strobe(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            case (which)
                0: tx_push = 1'b1;
                1: tx_pop  = 1'b1;
                2: rx_push = 1'b1;
                default: rx_pop = 1'b1;
            endcase
            @(posedge clk);
            #1;
            tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
        end
    endtask

    task automatic load_burst(input logic [15:0] len);
        @(negedge clk);
        bload = 1'b1;
        blen  = len;
        @(posedge clk);
        #1 bload = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        total++;
        if (irq !== e) begin
            bad++;
            $display("FAIL %s: irq got %b expected %b", t, irq, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_irq(1'b0, "R1 irq low in reset");
        @(negedge clk);
        rst_n = 1'b1;

        rd(8'h0C, 32'h0, "R1 enable reset value");
        rd(8'h1C, 32'h0, "R1 R9 levels after reset");
        idle(2);
        rd(8'h10, 32'h0000_1000, "R4 empty tx sets low flag");
        chk_irq(1'b0, "R8 pending but masked");

        // acknowledge while empty: one cycle clear, then back
        wr(8'h10, 32'h0000_1000);
        rd(8'h10, 32'h0, "R4 R3 cleared for one cycle");
        rd(8'h10, 32'h0000_1000, "R4 re-set while level holds");

        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, 32'h0001_1010, "R2 only three enable bits");
        chk_irq(1'b1, "R7 enabled pending source");

        wr(8'h0C, 32'h0);
        idle(1);
        chk_irq(1'b0, "R8 mask breaks the loop");

        // transmit threshold 17 -> 16
        strobe(0, 17);
        wr(8'h10, 32'h0000_1000);
        rd(8'h10, 32'h0, "R4 count 17 stays clear");
        rd(8'h1C, 32'h0011_0000, "R9 tx count 17");
        strobe(1, 1);
        idle(1);
        rd(8'h10, 32'h0000_1000, "R4 count 16 sets flag");

        // fill and overfill
        strobe(0, 48);
        strobe(0, 3);
        rd(8'h1C, 32'h0040_0000, "R10 push on full ignored");
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0, "R3 acknowledge all");

        // receive threshold and burst completion
        load_burst(16'd50);
        strobe(2, 47);
        wr(8'h10, 32'h0000_0010);
        rd(8'h10, 32'h0, "R5 count 47 below threshold");
        strobe(2, 1);
        idle(1);
        rd(8'h10, 32'h0000_0010, "R5 count 48 sets flag");
        strobe(2, 2);
        idle(1);
        rd(8'h10, 32'h0001_0010, "R6 done on last byte");
        wr(8'h10, 32'h0001_0000);
        rd(8'h10, 32'h0000_0010, "R6 R3 done acknowledged");
        idle(3);
        rd(8'h10, 32'h0000_0010, "R6 done not re-set");
        rd(8'h1C, 32'h0040_0032, "R9 both counts");

        strobe(3, 50);
        strobe(3, 2);
        rd(8'h1C, 32'h0040_0000, "R10 pop on empty ignored");
        rd(8'h04, 32'h0, "R11 unmapped offset");

        // done drives the interrupt
        load_burst(16'd1);
        strobe(2, 1);
        wr(8'h0C, 32'h0001_0000);
        idle(1);
        chk_irq(1'b1, "R7 done enabled");
        wr(8'h10, 32'h0001_0000);
        idle(1);
        chk_irq(1'b0, "R6 R7 done acknowledged");

        idle(2);
        if (exp_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard: %0d reads unanswered, expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule